// File: doc/BRIEF.md
# Key-Protected Clock and Power Control Register

This block keeps the clock and power settings of a chip in a byte-wide control register: a prescaler run bit, a CPU clock source select, one enable bit for each of the two oscillators, and a 2-bit system clock divide code. A second register, the key register, guards it. A write to the control register is accepted only while the key register holds the unlock key 0x96. Writing any other byte to the key register locks the control register again. The lock is not closed after each accepted write. It stays open until a non-key byte is written.

Software reaches both registers through a plain byte-wide write/read port with one address bit. Writes take effect at the clock edge. Read data is combinational and follows the address. A dropped write raises `wr_reject` for one cycle. The block also refuses a write that would move the CPU clock onto a disabled oscillator. In that case the select bit keeps its old value, the other fields are updated, and `sel_reject` pulses. The divide code is turned into `sysclk_en`, a one-cycle enable that repeats every 1, 2, 4 or 8 cycles. All pins are plain control and status pins, with no back-pressure. A write always completes in the cycle it is presented.

Top module: `clkpwr_guard`

## Requirements
- R1: After reset, the control register reads 0x47 (prescaler run, CPU select, high and low oscillator enables all 1, divide code 0) and the key register reads 0x00, so the control register starts locked.
- R2: A write of 0x96 to the key register (addr=1) unlocks the control register (addr=0), and the next control write takes effect at that clock edge.
- R3: A write of any value other than 0x96 to the key register locks the control register again. The key register reads back the last byte written to it.
- R4: A control write while locked leaves the control register unchanged, and `wr_reject` is 1 for exactly the cycle after that write.
- R5: The unlock stays open across any number of accepted control writes until a non-key byte is written to the key register.
- R6: Control bits 3 and 7 are reserved. They always read 0, whatever is written to them.
- R7: The divide code in control bits [5:4] makes `sysclk_en` high once every 1, 2, 4 or 8 cycles (codes 0, 1, 2, 3). The phase comes from a free-running cycle count that is 0 in the first cycle after reset.
- R8: An accepted write that changes control bit 2 (the CPU select) to a value whose oscillator enable is 0 in the written byte keeps the old select value. The other fields still take the written value, and `sel_reject` is 1 in the next cycle.
- R9: Control bit 6 drives `prescaler_run`, bit 2 drives `cpu_sel_hi` (1 selects the high-speed oscillator, 0 the low-speed one), bit 1 drives `osc_hi_en` and bit 0 drives `osc_lo_en`.
- R10: `rdata` shows the control register when addr=0 and the key register when addr=1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 1 | 0 selects the control register, 1 selects the key register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| prescaler_run | output | 1 | Prescaler run bit |
| cpu_sel_hi | output | 1 | CPU clock select: 1 high-speed, 0 low-speed oscillator |
| osc_hi_en | output | 1 | High-speed oscillator enable |
| osc_lo_en | output | 1 | Low-speed oscillator enable |
| sysclk_en | output | 1 | Divided system clock enable |
| wr_reject | output | 1 | One-cycle pulse after a control write dropped because the register was locked |
| sel_reject | output | 1 | One-cycle pulse after a refused CPU select change |

## Verification
The hardest situation to reach is a refused select change. The register must be unlocked, and the select must first be moved to the low-speed oscillator through a legal write. Then a write has to ask for the high-speed oscillator while disabling it in the same byte. The stimulus builds this state in steps: it unlocks, switches to low-speed, then writes 0x04. It also writes a byte that leaves the select pointing at an oscillator it just disabled, which must not count as a change. Then it relocks with a near-miss key (0x95) and shows that the next control write is dropped.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 2;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_KEY  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic             rsv_hi;
    logic             psc_run;
    logic [CODE_W-1:0] div;
    logic             rsv_lo;
    logic             cpu_sel;
    logic             osc_hi;
    logic             osc_lo;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{rsv_hi: 1'b0, psc_run: 1'b1, div: '0,
                                 rsv_lo: 1'b0, cpu_sel: 1'b1,
                                 osc_hi: 1'b1, osc_lo: 1'b1};
endpackage

// File: rtl/ckg_keylock.sv
module ckg_keylock #(
  parameter int          W   = 8,
  parameter logic [W-1:0] KEY = 8'h96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_key,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] key_q,
  output logic         unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (wr_key) key_q <= wdata;
  end

  assign unlocked = (key_q == KEY);
endmodule

// File: rtl/ckg_ctrlreg.sv
module ckg_ctrlreg
  import ckg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              unlocked,
  input  logic [BYTE_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic              wr_reject,
  output logic              sel_reject
);
  ctrl_t req;
  ctrl_t nxt;
  logic  target_on;
  logic  sel_bad;

  always_comb begin
    req        = ctrl_t'(wdata);
    req.rsv_lo = 1'b0;
    req.rsv_hi = 1'b0;
    target_on  = req.cpu_sel ? req.osc_hi : req.osc_lo;
    sel_bad    = (req.cpu_sel != ctrl_q.cpu_sel) && !target_on;
    nxt        = req;
    if (sel_bad) nxt.cpu_sel = ctrl_q.cpu_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RST;
      wr_reject  <= 1'b0;
      sel_reject <= 1'b0;
    end else begin
      if (wr_ctrl && unlocked) ctrl_q <= nxt;
      wr_reject  <= wr_ctrl && !unlocked;
      sel_reject <= wr_ctrl && unlocked && sel_bad;
    end
  end
endmodule

// File: rtl/ckg_divgen.sv
module ckg_divgen #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(code));
  end

  assign tick = ((cnt & mask) == '0);
endmodule

// File: rtl/clkpwr_guard.sv
module clkpwr_guard
  import ckg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] UNLOCK_KEY = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              prescaler_run,
  output logic              cpu_sel_hi,
  output logic              osc_hi_en,
  output logic              osc_lo_en,
  output logic              sysclk_en,
  output logic              wr_reject,
  output logic              sel_reject
);
  logic [BYTE_W-1:0] key_q;
  logic              unlocked;
  ctrl_t             ctrl_q;
  logic [CODE_W-1:0] div_code;
  logic              wr_key;
  logic              wr_ctrl;

  assign wr_key  = wr_en && (reg_sel_e'(addr) == SEL_KEY);
  assign wr_ctrl = wr_en && (reg_sel_e'(addr) == SEL_CTRL);

  ckg_keylock #(.W(BYTE_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_key(wr_key), .wdata(wdata),
    .key_q(key_q), .unlocked(unlocked)
  );

  ckg_ctrlreg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .unlocked(unlocked),
    .wdata(wdata), .ctrl_q(ctrl_q), .wr_reject(wr_reject),
    .sel_reject(sel_reject)
  );

  assign div_code = ctrl_q.div;

  ckg_divgen #(.CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .code(div_code), .tick(sysclk_en)
  );

  assign rdata         = (reg_sel_e'(addr) == SEL_KEY) ? key_q : BYTE_W'(ctrl_q);
  assign prescaler_run = ctrl_q.psc_run;
  assign cpu_sel_hi    = ctrl_q.cpu_sel;
  assign osc_hi_en     = ctrl_q.osc_hi;
  assign osc_lo_en     = ctrl_q.osc_lo;
endmodule

// File: rtl/clkpwr_guard_chk.sv
module clkpwr_guard_chk #(
  parameter logic [7:0] KEY = 8'h96
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] ctrl_byte,
  input logic       unlocked,
  input logic [1:0] div_code,
  input logic       wr_reject,
  input logic       sysclk_en,
  input logic       cpu_sel_hi,
  input logic       osc_hi_en,
  input logic       osc_lo_en
);
  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && wdata == KEY) |=> unlocked);

  assert_other_relocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && wdata != KEY) |=> !unlocked);

  assert_locked_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && !unlocked) |=> (wr_reject && $stable(ctrl_byte)));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_byte[3] == 1'b0 && ctrl_byte[7] == 1'b0));

  assert_div1_every_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == 2'd0) |-> sysclk_en);

  assert_sel_target_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_sel_hi) |-> (cpu_sel_hi ? osc_hi_en : osc_lo_en));
endmodule

bind clkpwr_guard clkpwr_guard_chk #(.KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctrl_byte(ctrl_q), .unlocked(unlocked), .div_code(div_code),
  .wr_reject(wr_reject), .sysclk_en(sysclk_en), .cpu_sel_hi(cpu_sel_hi),
  .osc_hi_en(osc_hi_en), .osc_lo_en(osc_lo_en)
);

// File: tb/tb_clkpwr_guard.sv
`timescale 1ns/1ps
module tb_clkpwr_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       prescaler_run, cpu_sel_hi, osc_hi_en, osc_lo_en;
  logic       sysclk_en, wr_reject, sel_reject;

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done = 0;

  // reference state
  logic [7:0] m_ctrl;
  logic [7:0] m_key;
  logic       m_wrrej, m_selrej;
  int         m_cnt;

  always #2 clk = ~clk;

  clkpwr_guard dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .prescaler_run(prescaler_run), .cpu_sel_hi(cpu_sel_hi),
    .osc_hi_en(osc_hi_en), .osc_lo_en(osc_lo_en), .sysclk_en(sysclk_en),
    .wr_reject(wr_reject), .sel_reject(sel_reject)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 8'h47; m_key = 8'h00; m_wrrej = 0; m_selrej = 0; m_cnt = 0;
    end else begin
      logic [7:0] req;
      m_wrrej = 0; m_selrej = 0;
      if (wr_en && !addr) begin
        if (m_key == 8'h96) begin
          req = wdata & 8'h77;
          if (req[2] != m_ctrl[2] && !(req[2] ? req[1] : req[0])) begin
            req[2] = m_ctrl[2];
            m_selrej = 1;
          end
          m_ctrl = req;
        end else m_wrrej = 1;
      end
      if (wr_en && addr) m_key = wdata;
      m_cnt++;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int per;
    per = 1 << m_ctrl[5:4];
    chk(phase, "rdata", rdata, addr ? m_key : m_ctrl);
    chk("R9", "prescaler_run", prescaler_run, m_ctrl[6]);
    chk("R9", "cpu_sel_hi", cpu_sel_hi, m_ctrl[2]);
    chk("R9", "osc_hi_en", osc_hi_en, m_ctrl[1]);
    chk("R9", "osc_lo_en", osc_lo_en, m_ctrl[0]);
    chk("R7", "sysclk_en", sysclk_en, (m_cnt % per) == 0);
    chk("R4", "wr_reject", wr_reject, m_wrrej);
    chk("R8", "sel_reject", sel_reject, m_selrej);
  endtask

  task automatic cyc(input logic we, input logic a, input logic [7:0] d);
    @(negedge clk);
    compare_all();
    wr_en = we; addr = a; wdata = d;
  endtask

  task automatic idle(input int n, input logic a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 8'h00);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1";
    idle(2, 1'b0);
    @(negedge clk); chk("R1", "reset ctrl", rdata, 8'h47);
    cyc(1'b0, 1'b1, 8'h00);
    @(negedge clk); chk("R1", "reset key", rdata, 8'h00);
    cyc(1'b0, 1'b0, 8'h00);

    phase = "R4";
    cyc(1'b1, 1'b0, 8'h00);
    idle(1, 1'b0);
    @(negedge clk); chk("R4", "locked ctrl kept", rdata, 8'h47);

    phase = "R2";
    cyc(1'b1, 1'b1, 8'h96);
    cyc(1'b1, 1'b0, 8'h57);
    idle(8, 1'b0);
    @(negedge clk); chk("R2", "unlocked write", rdata, 8'h57);

    phase = "R5";
    cyc(1'b1, 1'b0, 8'h67);
    idle(9, 1'b0);
    cyc(1'b1, 1'b0, 8'h77);
    idle(17, 1'b0);
    cyc(1'b1, 1'b0, 8'h47);
    idle(3, 1'b0);
    @(negedge clk); chk("R5", "still open", rdata, 8'h47);

    phase = "R6";
    cyc(1'b1, 1'b0, 8'hCF);
    idle(2, 1'b0);
    @(negedge clk); chk("R6", "reserved zero", rdata, 8'h47);

    phase = "R8";
    cyc(1'b1, 1'b0, 8'h41);
    cyc(1'b1, 1'b0, 8'h46);
    cyc(1'b1, 1'b0, 8'h45);
    cyc(1'b1, 1'b0, 8'h41);
    cyc(1'b1, 1'b0, 8'h04);
    idle(2, 1'b0);
    @(negedge clk); chk("R8", "select kept", rdata, 8'h00);
    cyc(1'b1, 1'b0, 8'h07);
    idle(2, 1'b0);

    phase = "R3";
    cyc(1'b1, 1'b1, 8'h95);
    idle(1, 1'b1);
    @(negedge clk); chk("R3", "key readback", rdata, 8'h95);
    cyc(1'b1, 1'b0, 8'h47);
    idle(2, 1'b0);
    @(negedge clk); chk("R3", "relocked drop", rdata, 8'h07);

    phase = "R10";
    idle(2, 1'b1);
    idle(2, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule